// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization

This block turns a fast system clock into the bit clock of a CAN receiver. A prescaler cuts the clock into time quanta. A phase sequencer walks each nominal bit through a one-quantum sync phase, a programmable first phase and a programmable second phase. The receive line is latched at the boundary between the two phases, which is the sample point. Edges on the line keep the local bit clock aligned with the transmitter.

A falling edge seen while the frame logic reports the bus idle restarts the bit at once (hard synchronization). Later falling edges shift the sample point (resynchronization), bounded by a programmable jump width. A late edge stretches the first phase. An early edge trims the second phase, or starts a new bit at once when it lies within the jump width of the bit end. Optional three-sample majority voting rejects single-quantum glitches. The frame decoder downstream uses the sampled bit and two strobes: one marks the sample point and one marks the start of each bit.

Top module: `can_bit_timing`

## Requirements
- R1: `timing0` holds the prescaler in bits [5:0] and the jump width SJW in bits [7:6]. One time quantum lasts 2×(prescaler+1) clocks.
- R2: `timing1` holds TSEG1 in bits [3:0], TSEG2 in bits [6:4] and the triple-sample enable in bit 7. With no synchronization event, `bit_start_stb` pulses once every TSEG1+TSEG2+3 quanta.
- R3: `sample_stb` pulses (TSEG1+2) quanta after `bit_start_stb`, which is the end of the first phase. `rx_bit` takes its new value in that same cycle and holds it until the next sample strobe.
- R4: The sync, first and second phases are mutually exclusive, and `sample_stb` and `bit_start_stb` are never high together.
- R5: A falling edge on `rx_in` while `bus_idle` is 1 raises `bit_start_stb` in the next cycle and restarts the quantum count. With `bus_idle` at 0, an edge never produces an immediate bit start unless R8 applies.
- R6: Rising edges on `rx_in` do not change the timing of either strobe.
- R7: A falling edge during the first phase, in its quantum n (counting from 0), lengthens that phase by min(n+1, SJW+1) quanta.
- R8: A falling edge during the second phase, with r quanta of that phase left (the current one included), starts a new bit at once when r ≤ SJW+1. Otherwise it shortens the second phase by SJW+1 quanta.
- R9: At most one resynchronization is applied per bit. A second falling edge in the same bit is ignored.
- R10: In single mode `rx_bit` is the line value on the sample-point clock. In triple mode it is the majority of the line values on the last clock of each of the two preceding quanta and on the sample-point clock.
- R11: After reset both strobes are 0, `rx_bit` is 1 (recessive) and the sequencer is in the sync phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timing0 | input | 8 | Jump width [7:6], prescaler [5:0] |
| timing1 | input | 8 | Triple enable [7], TSEG2 [6:4], TSEG1 [3:0] |
| bus_idle | input | 1 | High while the frame logic sees an idle bus; selects hard synchronization |
| rx_in | input | 1 | Receive line, 0 = dominant |
| rx_bit | output | 1 | Sampled bit value |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| bit_start_stb | output | 1 | One-cycle pulse on entry to the sync phase |

## Verification
Two timing settings with a quiet line set the quantum length and the phase lengths apart from each other. A falling edge on an idle bus fixes a known phase origin for each scenario. From that origin, single edges at chosen quanta separate the capped and uncapped stretch of the first phase. They also separate the trimmed second phase from the immediate restart. A second edge in the same bit and rising-only edges show that neither moves the strobes. A one-clock pulse, and a longer pulse, placed on the sample point tell single sampling from majority voting.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_ONE  = 2'd1,
        PH_TWO  = 2'd2
    } phase_e;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/can_bt_quanta.sv
module can_bt_quanta #(
    parameter int PRESC_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] presc,
    input  logic               restart,
    output logic               tick
);
    localparam int CNT_W = PRESC_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [CNT_W-1:0] last_clk;

    always_comb begin
        pre_d    = pre_q;
        // a quantum is 2*(presc+1) clocks, so its last count is 2*presc+1
        last_clk = {presc, 1'b1};
        tick     = (pre_q.cnt >= last_clk);
        if (restart || tick) begin
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = pre_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    // after a restart the next quantum lasts at least two clocks
    assert_restart_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);

    // quanta never shorter than two clocks
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler
    import can_bt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    input  logic tick,
    input  logic sample_now,
    input  logic triple,
    output logic rx_fall,
    output logic bit_out
);
    typedef struct packed {
        logic       prev;
        logic [1:0] hist;
        logic       bitv;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        smp_d.prev = rx_in;
        rx_fall    = smp_q.prev & ~rx_in;
        if (sample_now) begin
            smp_d.bitv = triple ? vote3(smp_q.hist[1], smp_q.hist[0], rx_in) : rx_in;
        end
        if (tick) begin
            smp_d.hist = {smp_q.hist[0], rx_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '{prev: 1'b1, hist: 2'b11, bitv: 1'b1};
        end else begin
            smp_q <= smp_d;
        end
    end

    assign bit_out = smp_q.bitv;

    assert_bit_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_now |=> $stable(bit_out));

    assert_vote_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_now && triple && smp_q.hist == 2'b00) |=> !bit_out);

endmodule

// File: rtl/can_bt_phase.sv
module can_bt_phase
    import can_bt_pkg::*;
#(
    parameter int SJW_W = 2,
    parameter int PH1_W = 4,
    parameter int PH2_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rx_fall,
    input  logic             bus_idle,
    input  logic [SJW_W-1:0] sjw,
    input  logic [PH1_W-1:0] tseg1,
    input  logic [PH2_W-1:0] tseg2,
    output logic             restart,
    output logic             sample_now,
    output logic             bit_start,
    output logic             sample_point
);
    localparam int Q_W = ((PH1_W > PH2_W) ? PH1_W : PH2_W) + 2;

    typedef struct packed {
        phase_e         ph;
        logic [Q_W-1:0] q;
        logic [Q_W-1:0] ext;
        logic [Q_W-1:0] shr;
        logic           rs_done;
        logic           bs;
        logic           sp;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic           go_sync, go_one, go_two;
    logic           may_rs, late, early;
    logic [Q_W-1:0] cap, ph1_len, ph2_len, elapsed, ext_new, remain;
    logic [Q_W-1:0] ext_eff, shr_eff, ph1_last, ph2_last;

    always_comb begin
        fsm_d   = fsm_q;
        go_sync = 1'b0;
        go_one  = 1'b0;
        go_two  = 1'b0;

        cap     = Q_W'(sjw) + 1'b1;
        ph1_len = Q_W'(tseg1) + 1'b1;
        ph2_len = Q_W'(tseg2) + 1'b1;

        elapsed = fsm_q.q + 1'b1;
        ext_new = (elapsed < cap) ? elapsed : cap;
        remain  = ph2_len - fsm_q.q;

        may_rs  = rx_fall & ~bus_idle & ~fsm_q.rs_done;
        late    = may_rs & (fsm_q.ph == PH_ONE);
        early   = may_rs & (fsm_q.ph == PH_TWO);
        restart = (rx_fall & bus_idle) | (early & (remain <= cap));

        ext_eff  = late  ? ext_new : fsm_q.ext;
        shr_eff  = early ? cap     : fsm_q.shr;
        ph1_last = ph1_len + ext_eff - 1'b1;
        ph2_last = ph2_len - shr_eff - 1'b1;

        if (late || early) begin
            fsm_d.rs_done = 1'b1;
            fsm_d.ext     = ext_eff;
            fsm_d.shr     = shr_eff;
        end

        if (restart) begin
            go_sync = 1'b1;
        end else if (tick) begin
            unique case (fsm_q.ph)
                PH_SYNC: begin
                    go_one = 1'b1;
                end
                PH_ONE: begin
                    if (fsm_q.q >= ph1_last) begin
                        go_two = 1'b1;
                    end else begin
                        fsm_d.q = fsm_q.q + 1'b1;
                    end
                end
                PH_TWO: begin
                    if (fsm_q.q >= ph2_last) begin
                        go_sync = 1'b1;
                    end else begin
                        fsm_d.q = fsm_q.q + 1'b1;
                    end
                end
                default: begin
                    go_sync = 1'b1;
                end
            endcase
        end

        if (go_sync) begin
            fsm_d.ph      = PH_SYNC;
            fsm_d.q       = '0;
            fsm_d.ext     = '0;
            fsm_d.shr     = '0;
            fsm_d.rs_done = 1'b0;
        end else if (go_one) begin
            fsm_d.ph = PH_ONE;
            fsm_d.q  = '0;
        end else if (go_two) begin
            fsm_d.ph = PH_TWO;
            fsm_d.q  = '0;
        end

        fsm_d.bs   = go_sync;
        fsm_d.sp   = go_two;
        sample_now = go_two;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{ph: PH_SYNC, q: '0, ext: '0, shr: '0, rs_done: 1'b0, bs: 1'b0, sp: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign bit_start    = fsm_q.bs;
    assign sample_point = fsm_q.sp;

    assert_one_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_sync, go_one, go_two}));

    assert_strobes_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_start && sample_point));

    assert_start_in_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_start |-> (fsm_q.ph == PH_SYNC));

    assert_sample_enters_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_point |-> (fsm_q.ph == PH_TWO));

    assert_ext_capped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        late |=> (fsm_q.ext != '0));

    assert_single_resync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.rs_done && !go_sync) |=> ($stable(fsm_q.ext) && $stable(fsm_q.shr)));

endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing #(
    parameter int PRESC_W = 6,
    parameter int SJW_W   = 2,
    parameter int PH1_W   = 4,
    parameter int PH2_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SJW_W+PRESC_W-1:0]   timing0,
    input  logic [PH2_W+PH1_W:0]       timing1,
    input  logic                       bus_idle,
    input  logic                       rx_in,
    output logic                       rx_bit,
    output logic                       sample_stb,
    output logic                       bit_start_stb
);
    localparam int T1_TOP = PH2_W + PH1_W;

    logic [PRESC_W-1:0] presc;
    logic [SJW_W-1:0]   sjw;
    logic [PH1_W-1:0]   tseg1;
    logic [PH2_W-1:0]   tseg2;
    logic               triple;
    logic               tick, restart, rx_fall, sample_now;

    assign presc  = timing0[PRESC_W-1:0];
    assign sjw    = timing0[SJW_W+PRESC_W-1:PRESC_W];
    assign tseg1  = timing1[PH1_W-1:0];
    assign tseg2  = timing1[T1_TOP-1:PH1_W];
    assign triple = timing1[T1_TOP];

    can_bt_quanta #(.PRESC_W(PRESC_W)) u_quanta (
        .clk     (clk),
        .rst_n   (rst_n),
        .presc   (presc),
        .restart (restart),
        .tick    (tick)
    );

    can_bt_phase #(.SJW_W(SJW_W), .PH1_W(PH1_W), .PH2_W(PH2_W)) u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .rx_fall      (rx_fall),
        .bus_idle     (bus_idle),
        .sjw          (sjw),
        .tseg1        (tseg1),
        .tseg2        (tseg2),
        .restart      (restart),
        .sample_now   (sample_now),
        .bit_start    (bit_start_stb),
        .sample_point (sample_stb)
    );

    can_bt_sampler u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_in      (rx_in),
        .tick       (tick),
        .sample_now (sample_now),
        .triple     (triple),
        .rx_fall    (rx_fall),
        .bit_out    (rx_bit)
    );

endmodule

// File: tb/can_bit_timing_test.sv
`timescale 1ns/1ps
module can_bit_timing_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] timing0 = 8'h41;
    logic [7:0] timing1 = 8'h23;
    logic       bus_idle = 1'b1;
    logic       rx_in = 1'b1;
    logic       rx_bit, sample_stb, bit_start_stb;

    int checks = 0;
    int errors = 0;
    int pos = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    can_bit_timing uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .timing0       (timing0),
        .timing1       (timing1),
        .bus_idle      (bus_idle),
        .rx_in         (rx_in),
        .rx_bit        (rx_bit),
        .sample_stb    (sample_stb),
        .bit_start_stb (bit_start_stb)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at offset %0d: got %0d expected %0d", req, pos, act, exp);
        end
    endtask

    // drive rx so that it is seen at the edge with offset m from the sync origin
    task automatic drive_at(input int m, input logic v);
        repeat (m - 1 - pos) @(posedge clk);
        @(negedge clk);
        rx_in = v;
        pos = m - 1;
    endtask

    // move to 1 ns after the edge with offset m
    task automatic goto(input int m);
        repeat (m - pos) @(posedge clk);
        #1;
        pos = m;
    endtask

    task automatic set_cfg(input logic [7:0] t0, input logic [7:0] t1);
        @(negedge clk);
        timing0 = t0;
        timing1 = t1;
    endtask

    // hard synchronization: origin 0 is the edge that sees the fall
    task automatic hsync();
        @(negedge clk);
        rx_in = 1'b1;
        bus_idle = 1'b1;
        repeat (3) @(negedge clk);
        rx_in = 1'b0;
        @(posedge clk);
        #1;
        pos = 0;
        check("R5 hard sync strobe", bit_start_stb, 1);
        bus_idle = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 reset sample_stb", sample_stb, 0);
        check("R11 reset bit_start_stb", bit_start_stb, 0);
        check("R11 reset rx_bit", rx_bit, 1);
    endtask

    // quantum 4 clocks, bit 8 quanta, sample after 5 quanta
    task automatic t_timing_a();
        set_cfg(8'h41, 8'h23);
        hsync();
        goto(19); check("R3 no early sample", sample_stb, 0);
        goto(20); check("R3 sample point A", sample_stb, 1);
        check("R4 strobes apart", bit_start_stb, 0);
        check("R3 rx_bit low", rx_bit, 0);
        goto(31); check("R2 no early bit start", bit_start_stb, 0);
        goto(32); check("R2 bit start A", bit_start_stb, 1);
        goto(52); check("R1 second sample A", sample_stb, 1);
        goto(64); check("R1 second bit start A", bit_start_stb, 1);
    endtask

    // quantum 2 clocks, bit 9 quanta, sample after 7 quanta
    task automatic t_timing_b();
        set_cfg(8'h40, 8'h15);
        hsync();
        goto(14); check("R3 sample point B", sample_stb, 1);
        goto(17); check("R2 no early bit start B", bit_start_stb, 0);
        goto(18); check("R2 bit start B", bit_start_stb, 1);
        goto(36); check("R1 second bit start B", bit_start_stb, 1);
    endtask

    task automatic t_late();
        set_cfg(8'h41, 8'h23);
        hsync();
        drive_at(2, 1'b1);
        drive_at(6, 1'b0);
        goto(6); check("R5 no bit start without idle", bit_start_stb, 0);
        drive_at(8, 1'b1);
        drive_at(10, 1'b0);
        goto(20); check("R7 sample moved from 20", sample_stb, 0);
        goto(24); check("R9 sample at 24 one resync", sample_stb, 1);
        check("R3 rx_bit after late", rx_bit, 0);
        goto(36); check("R7 bit start at 36", bit_start_stb, 1);
    endtask

    task automatic t_cap();
        hsync();
        drive_at(10, 1'b1);
        drive_at(14, 1'b0);
        goto(24); check("R7 capped not at 24", sample_stb, 0);
        goto(28); check("R7 capped sample at 28", sample_stb, 1);
    endtask

    task automatic t_early_short();
        hsync();
        drive_at(21, 1'b1);
        drive_at(22, 1'b0);
        goto(22); check("R8 no restart when far", bit_start_stb, 0);
        goto(24); check("R8 shortened bit start", bit_start_stb, 1);
        goto(44); check("R8 sample after short bit", sample_stb, 1);
    endtask

    task automatic t_early_restart();
        hsync();
        drive_at(29, 1'b1);
        drive_at(30, 1'b0);
        goto(30); check("R8 immediate restart", bit_start_stb, 1);
        goto(50); check("R8 sample after restart", sample_stb, 1);
    endtask

    task automatic t_rise();
        hsync();
        drive_at(6, 1'b1);
        goto(20); check("R6 sample unmoved", sample_stb, 1);
        check("R6 rx_bit high", rx_bit, 1);
        goto(32); check("R6 bit start unmoved", bit_start_stb, 1);
    endtask

    task automatic t_glitch(input logic [7:0] t1, input int exp_bit, input string req);
        set_cfg(8'h41, t1);
        hsync();
        drive_at(20, 1'b1);
        goto(20); check(req, sample_stb, 1);
        check(req, rx_bit, exp_bit);
        drive_at(21, 1'b0);
        goto(40);
    endtask

    task automatic t_vote_two_high();
        set_cfg(8'h41, 8'hA3);
        hsync();
        drive_at(16, 1'b1);
        goto(20); check("R10 triple two of three high", rx_bit, 1);
        drive_at(22, 1'b0);
        goto(40);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_timing_a();
        t_timing_b();
        t_late();
        t_cap();
        t_early_short();
        t_early_restart();
        t_rise();
        t_glitch(8'h23, 1, "R10 single glitch taken");
        t_glitch(8'hA3, 0, "R10 triple glitch voted out");
        t_vote_two_high();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule